// File: doc/BRIEF.md
# Asynchronous timer register update bridge

This block connects a register port in the system clock domain to an 8-bit timer whose registers may be clocked by a separate, unrelated oscillator. Software writes the counter, compare and control values into bus-side holding registers. Each value is then carried into the timer clock domain by a toggle handshake. A per-register busy flag stays set from the write until the timer side has taken the value. Software polls the flag before it writes that register again.

One status register holds the timer clock-source select and the three busy flags. When the select is 0, the timer registers run on the system clock, and a transfer finishes a few cycles after the write. When the select is 1, they run on the external clock input, and a transfer lasts as long as that clock needs to complete the handshake. The counter reads back its live value through a Gray-coded synchronizer. The compare and control registers read back their bus-side holding registers.

Register map (address: register): 0 status, 1 counter, 2 compare, 3 control. Control bit 0 enables counting.

Top module: `tmr_xfer_bridge`

## Requirements
- R1: After reset, all four addresses read 0x00, and the timer-side counter, compare and control outputs are 0.
- R2: Status bits 7 to 4 always read 0, even after a write of ones to them.
- R3: Status bit 3 is the clock-source select and reads back the value last written to it. Writes to status bits 2 to 0 have no effect on the busy flags.
- R4: A write to address 1, 2 or 3 while its flag is clear sets that register's busy flag in the next cycle: status bit 2 for the counter, bit 1 for compare, bit 0 for control.
- R5: When a busy flag clears, the timer-side register already holds the written value.
- R6: With select 0, a busy flag clears within 8 system clock cycles of the write.
- R7: With select 1, a busy flag stays set for as long as the external clock is stopped, and clears after that clock runs again.
- R8: Reading address 2 or 3 returns the holding register, which equals the last accepted write, including while the transfer is pending.
- R9: Reading address 1 returns the live count. With control bit 0 clear, this is the written value once the transfer has finished. With control bit 0 set and select 0, the count advances by exactly one per system clock cycle.
- R10: A write to a register whose busy flag is set is ignored. The holding register and the transferred value keep the earlier write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ext_clk | input | 1 | External timer clock, used when the select bit is 1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| t_cnt | output | 8 | Timer-domain counter value |
| t_cmp | output | 8 | Timer-domain compare value |
| t_ctl | output | 8 | Timer-domain control value |

## Verification
Suppose a toggle or synchronizer stage sits in the wrong state. The busy flag then never clears, or it clears before the timer-side output has changed. In select-0 mode this shows at the status read or at the t_* ports within eight cycles. A holding register that is overwritten during a transfer shows at once in the compare and control read-back, and a few cycles later at t_cmp or t_ctl. A wrong counter conversion shows as a read-back step that is not one per cycle.

// File: rtl/tmr_xfer_pkg.sv
package tmr_xfer_pkg;
  parameter int TMR_W = 8;
  parameter int NCH   = 3;  // 0 counter, 1 compare, 2 control

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_CNT  = 2'd1,
    REG_CMP  = 2'd2,
    REG_CTL  = 2'd3
  } reg_addr_e;

  localparam int STAT_SEL = 3;

  function automatic logic [TMR_W-1:0] bin2gray(input logic [TMR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [TMR_W-1:0] gray2bin(input logic [TMR_W-1:0] g);
    logic [TMR_W-1:0] b;
    b[TMR_W-1] = g[TMR_W-1];
    for (int i = TMR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // status byte: reserved zeros, select, busy flags (counter, compare, control)
  function automatic logic [TMR_W-1:0] pack_status(input logic sel,
                                                    input logic [NCH-1:0] busy);
    logic [TMR_W-1:0] s;
    s = '0;
    s[STAT_SEL] = sel;
    for (int c = 0; c < NCH; c++) s[NCH-1-c] = busy[c];
    return s;
  endfunction
endpackage

// File: rtl/tmr_bit_sync.sv
module tmr_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end
  assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr_xfer_chan.sv
module tmr_xfer_chan #(
  parameter int W = 8
) (
  input  logic         bclk,
  input  logic         tclk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] hold,
  output logic         busy,
  output logic         t_load
);
  logic req_b, ack_s, req_t, ack_t;

  assign busy = req_b ^ ack_s;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_b <= 1'b0;
      hold  <= '0;
    end else if (wr && !busy) begin
      req_b <= ~req_b;
      hold  <= wdata;
    end
  end

  tmr_bit_sync #(.STAGES(2)) u_req_sync (.clk(tclk), .rst_n(rst_n), .d(req_b), .q(req_t));

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) ack_t <= 1'b0;
    else        ack_t <= req_t;
  end
  assign t_load = req_t ^ ack_t;

  tmr_bit_sync #(.STAGES(2)) u_ack_sync (.clk(bclk), .rst_n(rst_n), .d(ack_t), .q(ack_s));
endmodule

// File: rtl/tmr_cnt_readback.sv
module tmr_cnt_readback
  import tmr_xfer_pkg::*;
(
  input  logic             tclk,
  input  logic             bclk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] cnt_next,
  output logic [TMR_W-1:0] cnt_rd
);
  logic [TMR_W-1:0] gray_t, gray_s1, gray_s2;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) gray_t <= '0;
    else        gray_t <= bin2gray(cnt_next);
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      gray_s1 <= '0;
      gray_s2 <= '0;
    end else begin
      gray_s1 <= gray_t;
      gray_s2 <= gray_s1;
    end
  end

  assign cnt_rd = gray2bin(gray_s2);
endmodule

// File: rtl/tmr_xfer_bridge.sv
module tmr_xfer_bridge
  import tmr_xfer_pkg::*;
(
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [TMR_W-1:0] wdata,
  output logic [TMR_W-1:0] rdata,
  output logic [TMR_W-1:0] t_cnt,
  output logic [TMR_W-1:0] t_cmp,
  output logic [TMR_W-1:0] t_ctl
);
  logic                      sel_q;
  logic                      tclk;
  logic [NCH-1:0]            wr_hit;
  logic [NCH-1:0]            busy_w;
  logic [NCH-1:0]            load_w;
  logic [NCH-1:0][TMR_W-1:0] hold_w;
  logic [TMR_W-1:0]          cnt_next;
  logic [TMR_W-1:0]          cnt_rd;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)                              sel_q <= 1'b0;
    else if (wr_en && addr == 2'(REG_STAT))  sel_q <= wdata[STAT_SEL];
  end

  assign tclk = sel_q ? ext_clk : sys_clk;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign wr_hit[c] = wr_en && (addr == 2'(c + 1));
    tmr_xfer_chan #(.W(TMR_W)) u_chan (
      .bclk  (sys_clk),
      .tclk  (tclk),
      .rst_n (rst_n),
      .wr    (wr_hit[c]),
      .wdata (wdata),
      .hold  (hold_w[c]),
      .busy  (busy_w[c]),
      .t_load(load_w[c])
    );
  end

  always_comb begin
    if (load_w[0])     cnt_next = hold_w[0];
    else if (t_ctl[0]) cnt_next = t_cnt + 1'b1;
    else               cnt_next = t_cnt;
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      t_cnt <= '0;
      t_cmp <= '0;
      t_ctl <= '0;
    end else begin
      t_cnt <= cnt_next;
      if (load_w[1]) t_cmp <= hold_w[1];
      if (load_w[2]) t_ctl <= hold_w[2];
    end
  end

  tmr_cnt_readback u_rb (
    .tclk    (tclk),
    .bclk    (sys_clk),
    .rst_n   (rst_n),
    .cnt_next(cnt_next),
    .cnt_rd  (cnt_rd)
  );

  always_comb begin
    unique case (addr)
      2'(REG_STAT): rdata = pack_status(sel_q, busy_w);
      2'(REG_CNT):  rdata = cnt_rd;
      2'(REG_CMP):  rdata = hold_w[1];
      default:      rdata = hold_w[2];
    endcase
  end
endmodule

// File: rtl/tmr_xfer_chk.sv
module tmr_xfer_chk
  import tmr_xfer_pkg::*;
(
  input logic                      sys_clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [1:0]                addr,
  input logic [TMR_W-1:0]          wdata,
  input logic [TMR_W-1:0]          rdata,
  input logic                      sel_q,
  input logic [NCH-1:0]            wr_hit,
  input logic [NCH-1:0]            busy_w,
  input logic [NCH-1:0][TMR_W-1:0] hold_w,
  input logic [TMR_W-1:0]          t_cmp,
  input logic [TMR_W-1:0]          t_ctl
);
  localparam int SYNC_LIMIT = 8;

  a_r2_reserved_zero: assert property (@(posedge sys_clk) disable iff (!rst_n)
    addr == 2'(REG_STAT) |-> rdata[TMR_W-1:4] == '0);

  a_r3_sel_write: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (wr_en && addr == 2'(REG_STAT)) |=> sel_q == $past(wdata[STAT_SEL]));

  a_r5_cmp_loaded: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(busy_w[1]) |-> t_cmp == hold_w[1]);

  a_r5_ctl_loaded: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(busy_w[2]) |-> t_ctl == hold_w[2]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [4:0] age;
    always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n)                  age <= '0;
      else if (busy_w[c] && !sel_q) age <= (age == 5'd31) ? age : age + 1'b1;
      else                         age <= '0;
    end

    a_r4_busy_on_write: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (wr_hit[c] && !busy_w[c]) |=> busy_w[c]);

    a_r10_hold_stable: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (busy_w[c] && $past(busy_w[c])) |-> $stable(hold_w[c]));

    a_r6_sync_bound: assert property (@(posedge sys_clk) disable iff (!rst_n)
      age <= 5'(SYNC_LIMIT));
  end
endmodule

bind tmr_xfer_bridge tmr_xfer_chk u_chk (
  .sys_clk(sys_clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .sel_q  (sel_q),
  .wr_hit (wr_hit),
  .busy_w (busy_w),
  .hold_w (hold_w),
  .t_cmp  (t_cmp),
  .t_ctl  (t_ctl)
);

// File: tb/tmr_xfer_bridge_bench.sv
module tmr_xfer_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_HALF   = 17;

  logic       sys_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ext_run = 1'b1;
  logic       rst_n   = 1'b0;
  logic       wr_en   = 1'b0;
  logic [1:0] addr    = 2'd0;
  logic [7:0] wdata   = 8'd0;
  logic [7:0] rdata, t_cnt, t_cmp, t_ctl;

  int n_chk = 0;
  int n_err = 0;

  // behavioural reference state
  logic       m_sel = 1'b0;
  logic [7:0] m_hold [3];
  logic       m_busy [3];
  logic       m_fresh[3];
  int         m_age  [3];

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
  always #EXT_HALF if (ext_run) ext_clk = ~ext_clk;

  tmr_xfer_bridge u_tmr_xfer_bridge (
    .sys_clk(sys_clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .t_cnt(t_cnt), .t_cmp(t_cmp), .t_ctl(t_ctl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] t_val(input int c);
    return (c == 0) ? t_cnt : (c == 1) ? t_cmp : t_ctl;
  endfunction

  // per-clock comparison against the reference
  always @(negedge sys_clk) begin
    #1;
    if (rst_n) begin
      if (addr == 2'd0) begin
        chk(rdata[7:4] == 4'd0, "R2", rdata[7:4], 0);
        chk(rdata[3] == m_sel, "R3", rdata[3], m_sel);
        for (int c = 0; c < 3; c++) begin
          logic b;
          b = rdata[2-c];
          if (m_fresh[c]) begin
            chk(b == 1'b1, "R4", b, 1);
            m_fresh[c] = 1'b0;
          end else if (m_busy[c] && !b) begin
            m_busy[c] = 1'b0;
            if (c != 0 || !m_hold[2][0])
              chk(t_val(c) == m_hold[c], "R5", t_val(c), m_hold[c]);
          end else if (!m_busy[c]) begin
            chk(b == 1'b0, "R3", b, 0);
          end
        end
      end else if (addr >= 2'd2) begin
        chk(rdata == m_hold[addr-1], "R8", rdata, m_hold[addr-1]);
      end
      for (int c = 0; c < 3; c++) begin
        if (m_busy[c] && !m_sel) m_age[c]++;
        else                     m_age[c] = 0;
        if (m_age[c] == 9) chk(1'b0, "R6", m_age[c], 8);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge sys_clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge sys_clk);
    wr_en = 1'b0; addr = 2'd0;
    if (a == 2'd0) m_sel = d[3];
    else if (!m_busy[a-1]) begin
      m_hold[a-1]  = d;
      m_busy[a-1]  = 1'b1;
      m_fresh[a-1] = 1'b1;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge sys_clk);
    addr = a;
    #1 d = rdata;
    #3 addr = 2'd0;
  endtask

  task automatic wait_idle(input int limit);
    int n;
    n = 0;
    while ((m_busy[0] || m_busy[1] || m_busy[2]) && n < limit) begin
      @(negedge sys_clk); #2; n++;
    end
    chk(n < limit, "R7", n, limit);
  endtask

  logic [7:0] v, v2;

  initial begin
    for (int c = 0; c < 3; c++) begin
      m_hold[c] = 8'd0; m_busy[c] = 1'b0; m_fresh[c] = 1'b0; m_age[c] = 0;
    end
    repeat (3) @(negedge sys_clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 8'h00, "R1", v, 0);
    end
    chk({t_cnt, t_cmp, t_ctl} == 24'd0, "R1", {t_cnt, t_cmp, t_ctl}, 0);

    // R2/R3: reserved and busy bits are not writable
    wr(2'd0, 8'hF7);
    rd(2'd0, v);
    chk(v == 8'h00, "R2", v, 0);

    // R8/R4/R5/R6: compare transfer on the system clock
    wr(2'd2, 8'h5A);
    rd(2'd2, v);
    chk(v == 8'h5A, "R8", v, 8'h5A);
    wait_idle(20);
    chk(t_cmp == 8'h5A, "R5", t_cmp, 8'h5A);

    // R9: counter load with counting stopped
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h37);
    wait_idle(20);
    repeat (4) @(negedge sys_clk);
    rd(2'd1, v);
    chk(v == 8'h37, "R9", v, 8'h37);

    // R10: second write while busy is dropped
    @(negedge sys_clk);
    addr = 2'd2; wdata = 8'h11; wr_en = 1'b1;
    @(negedge sys_clk);
    m_hold[1] = 8'h11; m_busy[1] = 1'b1; m_fresh[1] = 1'b0;
    wdata = 8'h22;
    @(negedge sys_clk);
    wr_en = 1'b0;
    #1 chk(rdata == 8'h11, "R10", rdata, 8'h11);
    #3 addr = 2'd0;
    wait_idle(20);
    chk(t_cmp == 8'h11, "R10", t_cmp, 8'h11);

    // R9: running counter advances one per cycle
    wr(2'd3, 8'h01);
    wait_idle(20);
    repeat (3) @(negedge sys_clk);
    rd(2'd1, v);
    repeat (9) @(negedge sys_clk);
    rd(2'd1, v2);
    chk(8'(v2 - v) == 8'd10, "R9", 8'(v2 - v), 10);
    wr(2'd3, 8'h00);
    wait_idle(20);

    // R3/R7: external clock mode
    wr(2'd0, 8'h08);
    rd(2'd0, v);
    chk(v[3] == 1'b1, "R3", v[3], 1);
    wr(2'd3, 8'h02);
    wait_idle(200);
    chk(t_ctl == 8'h02, "R7", t_ctl, 8'h02);
    ext_run = 1'b0;
    wr(2'd2, 8'h99);
    repeat (30) @(negedge sys_clk);
    #1 chk(rdata[1] == 1'b1, "R7", rdata[1], 1);
    ext_run = 1'b1;
    wait_idle(200);
    chk(t_cmp == 8'h99, "R7", t_cmp, 8'h99);

    // back to the system clock
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h04);
    wait_idle(20);
    chk(t_ctl == 8'h04, "R6", t_ctl, 8'h04);

    repeat (5) @(negedge sys_clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule